// File: doc/BRIEF.md
# Joint-Phase Redundant State Selector

This block sits between a multilevel modulator and the gate drivers of a three-phase inverter built from three-cell flying-capacitor legs. The two flying capacitors and the source in each leg are held at a 1:2:4 voltage ratio. Each phase then has five output levels, and every intermediate level can be reached by two different cell combinations. For each new command the block receives one level per phase. It also receives the sign of each phase current, an overcharged/undercharged flag for each of the six capacitors, a per-phase flag that says which of the two capacitors in that leg has precedence, and the index of the capacitor that deviates most.

The block exploits two kinds of freedom. All three levels may be moved by the same amount, because a common shift leaves the line-to-line voltages unchanged. Inside each leg, either of the two equivalent cell combinations may be used. Each candidate is scored with fixed small-integer weights that reflect whether it drives each capacitor back toward its nominal voltage. The choice is made in two steps. First the shift that best serves the worst capacitor is chosen. Then each leg takes its best cell combination at that shift.

Evaluation is purely combinational. The result is captured in a register on the strobe edge and flagged by a one-cycle valid pulse.

Top module: `jrs_selector`

## Requirements
- R1: While `rst` is high at a clock edge, `gate` becomes all zeros and `out_vld` becomes 0.
- R2: `out_vld` is 1 in exactly the cycle that follows a cycle in which `cmd_stb` was 1, and is 0 otherwise.
- R3: `gate` changes only on the clock edge that samples `cmd_stb` high. At all other edges it holds its value.
- R4: The gate field of phase p is `gate[3p+2:3p]`, holding {s3,s2,s1} for phases a=0, b=1, c=2. The level of that field is s1+s2+2*s3. After a strobe, each phase's output level minus its commanded level is the same for all three phases, and every output level lies in 0..4.
- R5: The current through the lower capacitor of a leg is taken as (s2-s1) times the phase current sign, and through the upper capacitor as (s3-s2) times that sign. `i_pos[p]`=1 means positive current. `v_over[2p]` (lower capacitor) or `v_over[2p+1]` (upper capacitor) set to 1 means overcharged. A capacitor is helped when its current is positive and it is overcharged, or negative and it is undercharged. It is neutral at zero current and harmed otherwise.
- R6: A candidate code for a leg scores the sum of its two capacitor scores. The high-precedence capacitor scores 6 when helped, 3 when neutral and 0 when harmed. The other capacitor scores 2, 1 and 0. `pair_sel[p]`=0 gives precedence to the lower capacitor of phase p, and 1 to the upper.
- R7: `worst_cap` names capacitor index 2p+k, where k=0 is the lower and k=1 the upper capacitor. In the named phase that capacitor takes precedence, overriding `pair_sel`. Among all common shifts that keep every level in 0..4, the one whose best code for the named phase scores highest is chosen.
- R8: At the chosen shift, each of the other two phases uses its highest-scoring code for its shifted level, with precedence taken from its own `pair_sel` bit.
- R9: Score ties are broken first by the smallest shift, then by the numerically smallest code {s3,s2,s1}.
- R10: A commanded level above 4 is treated as 4. A `worst_cap` of 6 or 7 names the lower or upper capacitor of phase c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | New command present this cycle |
| cmd_lvl | input | 9 | Commanded levels, phase p in bits [3p+2:3p] |
| i_pos | input | 3 | Phase current sign per phase, 1 = positive |
| v_over | input | 6 | Capacitor overcharged flags, index 2p+k |
| pair_sel | input | 3 | Per-phase precedence, 0 = lower capacitor, 1 = upper |
| worst_cap | input | 3 | Index of the capacitor with the largest deviation |
| gate | output | 9 | Selected cell bits {s3,s2,s1} per phase |
| out_vld | output | 1 | One-cycle pulse marking a fresh selection |

## Verification
On every cycle the assertions check the valid pulse timing, the holding of the gate register between strobes, the reset values, and that the common shift stays legal. After every strobe they also check that the difference between any two phases' output levels equals the difference between their commanded levels. Whether the scoring, the precedence override and the tie-break order pick the right candidate can only be shown by the bench's scenarios. These are hand-worked vectors for help, harm and zero-current cases, saturation of out-of-range commands, and a long pseudo-random sweep compared against an independently written reference of the two-step selection.

// File: rtl/jrs_pkg.sv
package jrs_pkg;

    localparam int NPH   = 3;            // phases
    localparam int NCAP  = 2;            // flying capacitors per phase
    localparam int NCELL = 3;            // switching cells per phase
    localparam int NLVL  = 5;            // distinct output levels with 1:2:4
    localparam int LVLW  = 3;
    localparam int SCW   = 4;
    localparam int SHW   = $clog2(NLVL);
    localparam int NCODE = 1 << NCELL;
    localparam int MAXL  = NLVL - 1;

    typedef logic [NCELL-1:0] code_t;    // {s3, s2, s1}
    typedef logic [LVLW-1:0]  lvl_t;
    typedef logic [SCW-1:0]   score_t;
    typedef logic [SHW-1:0]   shift_t;

    typedef enum logic [1:0] {
        EFF_HURT = 2'd0,
        EFF_ZERO = 2'd1,
        EFF_HELP = 2'd2
    } eff_e;

    typedef struct packed {
        code_t  code;
        score_t score;
    } pick_t;

    localparam score_t SC_HI_HELP = 4'd6;
    localparam score_t SC_HI_ZERO = 4'd3;
    localparam score_t SC_LO_HELP = 4'd2;
    localparam score_t SC_LO_ZERO = 4'd1;
    localparam score_t SC_HURT    = 4'd0;

    // Output level of a cell code under the 1:2:4 ratio.
    function automatic lvl_t code_level(code_t c);
        return lvl_t'(c[0]) + lvl_t'(c[1]) + lvl_t'({c[2], 1'b0});
    endfunction

    // Effect of a code on one capacitor sitting between cell bits lo and hi.
    function automatic eff_e cap_effect(logic lo_bit, logic hi_bit,
                                        logic cur_pos, logic over);
        logic flow_pos;
        if (lo_bit == hi_bit) return EFF_ZERO;
        flow_pos = (hi_bit == cur_pos);
        return (flow_pos == over) ? EFF_HELP : EFF_HURT;
    endfunction

    function automatic score_t eff_score(eff_e e, logic high);
        case (e)
            EFF_HELP: return high ? SC_HI_HELP : SC_LO_HELP;
            EFF_ZERO: return high ? SC_HI_ZERO : SC_LO_ZERO;
            default:  return SC_HURT;
        endcase
    endfunction

    function automatic lvl_t sat_level(lvl_t l);
        return (l > lvl_t'(MAXL)) ? lvl_t'(MAXL) : l;
    endfunction

endpackage

// File: rtl/jrs_code_picker.sv
module jrs_code_picker
    import jrs_pkg::*;
(
    input  lvl_t             lvl,
    input  logic             cur_pos,
    input  logic [NCAP-1:0]  over,
    input  logic             hi_up,     // 1: upper capacitor has precedence
    output pick_t            best
);
    always_comb begin
        logic   found;
        score_t sc;
        code_t  cc;
        found      = 1'b0;
        best.code  = '0;
        best.score = '0;
        sc         = '0;
        cc         = '0;
        for (int c = 0; c < NCODE; c++) begin
            cc = code_t'(c);
            if (code_level(cc) == lvl) begin
                sc = eff_score(cap_effect(cc[0], cc[1], cur_pos, over[0]), !hi_up)
                   + eff_score(cap_effect(cc[1], cc[2], cur_pos, over[1]),  hi_up);
                if (!found || sc > best.score) begin
                    best.code  = cc;
                    best.score = sc;
                end
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/jrs_shift_ranker.sv
module jrs_shift_ranker
    import jrs_pkg::*;
(
    input  lvl_t             base,      // worst-phase level minus the minimum level
    input  lvl_t             span,      // max level minus min level
    input  logic             cur_pos,
    input  logic [NCAP-1:0]  over,
    input  logic             hi_up,
    output shift_t           best_j
);
    pick_t cand [NLVL];

    for (genvar j = 0; j < NLVL; j++) begin : g_shift
        jrs_code_picker u_pick (
            .lvl     (base + lvl_t'(j)),
            .cur_pos (cur_pos),
            .over    (over),
            .hi_up   (hi_up),
            .best    (cand[j])
        );
    end

    always_comb begin
        score_t top;
        best_j = '0;
        top    = cand[0].score;
        for (int j = 1; j < NLVL; j++) begin
            if ((int'(span) + j) <= MAXL && cand[j].score > top) begin
                top    = cand[j].score;
                best_j = shift_t'(j);
            end
        end
    end
endmodule

// File: rtl/jrs_selector.sv
module jrs_selector
    import jrs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_stb,
    input  logic [NPH*LVLW-1:0]  cmd_lvl,
    input  logic [NPH-1:0]       i_pos,
    input  logic [NPH*NCAP-1:0]  v_over,
    input  logic [NPH-1:0]       pair_sel,
    input  logic [2:0]           worst_cap,
    output logic [NPH*NCELL-1:0] gate,
    output logic                 out_vld
);
    lvl_t   lvl_sat [NPH];
    lvl_t   adj     [NPH];
    pick_t  pick    [NPH];
    logic   hi_up   [NPH];
    lvl_t   mn, mx, span, base;
    logic [1:0] wp;
    logic       wc;
    shift_t     best_j;
    logic [NPH*NCELL-1:0] gate_nx;

    // Saturation and common-mode range of the command.
    always_comb begin
        mn = lvl_t'(MAXL);
        mx = '0;
        for (int p = 0; p < NPH; p++) begin
            lvl_sat[p] = sat_level(cmd_lvl[p*LVLW +: LVLW]);
            if (lvl_sat[p] < mn) mn = lvl_sat[p];
            if (lvl_sat[p] > mx) mx = lvl_sat[p];
        end
        span = mx - mn;
    end

    // Worst capacitor decode: phase and which of its two capacitors.
    assign wp   = (worst_cap >= 3'd6) ? 2'd2 : worst_cap[2:1];
    assign wc   = worst_cap[0];
    assign base = lvl_sat[wp] - mn;

    // Step one: shift chosen for the worst capacitor's phase.
    jrs_shift_ranker u_rank (
        .base    (base),
        .span    (span),
        .cur_pos (i_pos[wp]),
        .over    (v_over[wp*NCAP +: NCAP]),
        .hi_up   (wc),
        .best_j  (best_j)
    );

    // Step two: per-phase code at the chosen shift.
    for (genvar p = 0; p < NPH; p++) begin : g_phase
        assign adj[p]   = lvl_sat[p] - mn + lvl_t'(best_j);
        assign hi_up[p] = (wp == 2'(p)) ? wc : pair_sel[p];
        jrs_code_picker u_pick (
            .lvl     (adj[p]),
            .cur_pos (i_pos[p]),
            .over    (v_over[p*NCAP +: NCAP]),
            .hi_up   (hi_up[p]),
            .best    (pick[p])
        );
        assign gate_nx[p*NCELL +: NCELL] = pick[p].code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate    <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= cmd_stb;
            if (cmd_stb) gate <= gate_nx;
        end
    end

    // R1: reset values
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (gate == '0 && !out_vld));

    // R2: valid follows strobe by one cycle
    a_r2_vld_pulse: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_vld == $past(cmd_stb)));

    // R3: no strobe, no change
    a_r3_gate_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cmd_stb)) |-> $stable(gate));

    // R4: common shift keeps phase-to-phase differences
    a_r4_line_diff: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !$past(rst)) |->
        ((4'(code_level(gate[2:0])) + 4'($past(lvl_sat[1])))
             == (4'(code_level(gate[5:3])) + 4'($past(lvl_sat[0])))
         && (4'(code_level(gate[5:3])) + 4'($past(lvl_sat[2])))
             == (4'(code_level(gate[8:6])) + 4'($past(lvl_sat[1])))));

    // R7: the chosen shift keeps every phase inside the level range
    a_r7_shift_legal: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> ((4'(span) + 4'(best_j)) <= 4'(MAXL)));

endmodule

// File: tb/jrs_selector_test.sv
module jrs_selector_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_stb = 1'b0;
    logic [8:0] cmd_lvl = '0;
    logic [2:0] i_pos = '0;
    logic [5:0] v_over = '0;
    logic [2:0] pair_sel = '0;
    logic [2:0] worst_cap = '0;
    logic [8:0] gate;
    logic       out_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    jrs_selector uut (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_lvl(cmd_lvl),
        .i_pos(i_pos), .v_over(v_over), .pair_sel(pair_sel),
        .worst_cap(worst_cap), .gate(gate), .out_vld(out_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {lvl[8:0], i_pos[2:0], v_over[5:0], pair_sel[2:0], worst[2:0], expected[8:0]}
    localparam int NV = 5;
    localparam logic [32:0] VEC [NV] = '{
        {9'b010_010_010, 3'b111, 6'b000000, 3'b000, 3'd0, 9'h049},
        {9'b010_100_000, 3'b111, 6'b111111, 3'b100, 3'd0, 9'h138},
        {9'b010_011_001, 3'b101, 6'b111000, 3'b000, 3'd3, 9'h098},
        {9'b000_101_111, 3'b000, 6'b000000, 3'b000, 3'd0, 9'h03F},
        {9'b000_000_000, 3'b111, 6'b000001, 3'b000, 3'd0, 9'h04A}
    };

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lvl_of(logic [2:0] c);
        return int'(c[0]) + int'(c[1]) + 2 * int'(c[2]);
    endfunction

    // Capacitor score from the requirement text.
    function automatic int cscore(int lo, int hi, bit cur, bit over, bit high);
        int d, f;
        d = hi - lo;
        f = cur ? d : -d;
        if (f == 0) return high ? 3 : 1;
        if ((over && f > 0) || (!over && f < 0)) return high ? 6 : 2;
        return 0;
    endfunction

    function automatic int code_score(int c, bit cur, logic [1:0] ov, bit up);
        int s1, s2, s3;
        s1 = c & 1; s2 = (c >> 1) & 1; s3 = (c >> 2) & 1;
        return cscore(s1, s2, cur, ov[0], !up) + cscore(s2, s3, cur, ov[1], up);
    endfunction

    function automatic int best_code(int lv, bit cur, logic [1:0] ov, bit up, output int sc);
        int bc;
        bc = -1; sc = -1;
        for (int c = 0; c < 8; c++) begin
            if (lvl_of(3'(c)) == lv && code_score(c, cur, ov, up) > sc) begin
                sc = code_score(c, cur, ov, up);
                bc = c;
            end
        end
        return bc;
    endfunction

    function automatic logic [8:0] model(logic [8:0] lv, logic [2:0] ip, logic [5:0] vo,
                                         logic [2:0] ps, logic [2:0] wk);
        int l [3];
        int lo, hi, wph, bj, bs, sc, c;
        bit wup;
        logic [8:0] g;
        lo = 4; hi = 0;
        for (int p = 0; p < 3; p++) begin
            l[p] = int'(lv[p*3 +: 3]);
            if (l[p] > 4) l[p] = 4;
            if (l[p] < lo) lo = l[p];
            if (l[p] > hi) hi = l[p];
        end
        wph = (wk >= 6) ? 2 : int'(wk) / 2;
        wup = wk[0];
        bj = 0; bs = -1;
        for (int k = -lo; k <= 4 - hi; k++) begin
            c = best_code(l[wph] + k, ip[wph], vo[wph*2 +: 2], wup, sc);
            if (sc > bs) begin bs = sc; bj = k; end
        end
        g = '0;
        for (int p = 0; p < 3; p++) begin
            c = best_code(l[p] + bj, ip[p], vo[p*2 +: 2], (p == wph) ? wup : ps[p], sc);
            g[p*3 +: 3] = 3'(c);
        end
        return g;
    endfunction

    task automatic apply(input logic [8:0] lv, input logic [2:0] ip, input logic [5:0] vo,
                         input logic [2:0] ps, input logic [2:0] wk);
        @(negedge clk);
        cmd_lvl = lv; i_pos = ip; v_over = vo; pair_sel = ps; worst_cap = wk;
        cmd_stb = 1'b1;
        @(negedge clk);
        cmd_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [8:0]  exp_g, lvr;
        int d0, d1, d2;
        repeat (3) @(negedge clk);
        chk("R1 reset gate", gate, 9'h000);
        chk("R1 reset valid", 9'(out_vld), 9'h000);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 no strobe no valid", 9'(out_vld), 9'h000);

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][32:24], VEC[v][23:21], VEC[v][20:15], VEC[v][14:12], VEC[v][11:9]);
            chk("R2 valid after strobe", 9'(out_vld), 9'h001);
            if (v == 3) chk("R10 level saturation", gate, VEC[v][8:0]);
            else        chk("R5 R6 R7 R8 vector", gate, VEC[v][8:0]);
            @(negedge clk);
            chk("R2 valid single cycle", 9'(out_vld), 9'h000);
        end

        // R3: inputs change without a strobe, gate holds
        exp_g = gate;
        cmd_lvl = 9'b100_000_011; i_pos = 3'b010; v_over = 6'b101010; worst_cap = 3'd5;
        repeat (3) @(negedge clk);
        chk("R3 hold without strobe", gate, exp_g);

        // R10: worst index 7 names upper capacitor of phase c
        apply(9'b001_010_011, 3'b011, 6'b100110, 3'b010, 3'd7);
        chk("R10 worst index 7", gate, model(9'b001_010_011, 3'b011, 6'b100110, 3'b010, 3'd7));

        // R9 R4: pseudo-random sweep against reference, including ties
        lfsr = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            for (int s = 0; s < 16; s++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            lvr = {3'(lfsr[2:0] % 5), 3'(lfsr[5:3] % 5), 3'(lfsr[8:6] % 5)};
            if (n % 37 == 0) lvr = lfsr[8:0];
            apply(lvr, lfsr[11:9], {lfsr[15:12], lfsr[1:0]}, lfsr[14:12], lfsr[6:4]);
            exp_g = model(lvr, lfsr[11:9], {lfsr[15:12], lfsr[1:0]}, lfsr[14:12], lfsr[6:4]);
            chk("R9 random selection", gate, exp_g);
            d0 = lvl_of(gate[2:0]) - (lvr[2:0] > 4 ? 4 : int'(lvr[2:0]));
            d1 = lvl_of(gate[5:3]) - (lvr[5:3] > 4 ? 4 : int'(lvr[5:3]));
            d2 = lvl_of(gate[8:6]) - (lvr[8:6] > 4 ? 4 : int'(lvr[8:6]));
            if (n % 25 == 0)
                chk("R4 common shift", 9'((d0 == d1 && d1 == d2) ? 1 : 0), 9'h001);
        end

        // R1: reset after activity clears outputs
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears gate", gate, 9'h000);
        rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule